// File: doc/BRIEF.md
# Replay Entry Wake-up Tracker

This block keeps the per-entry blocking state of a queue of memory loads that must be replayed. When a load is written into an entry, the entry records several items. The first is an 11-bit vector of the reasons the load failed. The others are a strict-ordering flag, the index of the store it depends on, the ID of the cache-miss tracker handling it, and the ID of its translation-miss request. From then on, the entry watches broadcast events each cycle and drops its blocked bit once the wake-up rule for its governing cause is met. The events are store addresses or store data becoming ready, translation and lower-cache hints carrying IDs, free space in side queues, and per-entry "all older store addresses known" and "oldest load" indications.

Selection logic uses the ready vector to pick entries for replay. A grant marks an entry as scheduled. A fresh write into the entry clears that mark and re-arms the entry, which covers a replay that fails again. A free pulse releases the entry. The store queue, the caches and the selection logic are outside this block and appear only as input signals.

Top module: `replay_wakeup_tracker`

## Requirements
- R1: After reset, every bit of `blocked_o` and `ready_o` is 0.
- R2: Cause bit 0 (ordering prediction hit) with the strict flag set wakes only on `older_addr_done_i` for that entry. A store-address broadcast does not wake it, even one that matches. With the strict flag clear, it wakes on `st_addr_vld_i` with `st_addr_idx_i` equal to the stored store index. A different index does not wake it.
- R3: Cause bit 1 (translation miss) is replayable at once if `enq_tlb_full_i` was 1 at the write. Otherwise it wakes on `tlb_hint_vld_i` with `tlb_hint_id_i` equal to the stored hint ID, and a mismatching ID does not wake it.
- R4: Cause bit 2 (store data not ready) wakes on `st_data_vld_i` with `st_data_idx_i` equal to the stored store index. An address broadcast for that store does not wake it.
- R5: Cause bit 4 (cache miss) wakes on `l2_hint_vld_i` with `l2_hint_id_i` equal to the stored miss ID. One hint wakes every entry holding that ID and no other entry.
- R6: Entries whose governing cause is bit 3, 5, 6 or 9 are never blocked, and neither are entries with an all-zero cause vector. They are ready in the cycle after the write.
- R7: Cause bit 7 (read-after-read queue full) wakes on `rar_space_i` or on the entry's bit of `oldest_i`. `raw_space_i` does not wake it.
- R8: Cause bit 8 (read-after-write queue full) wakes on `raw_space_i` or on the entry's bit of `older_addr_done_i`. `rar_space_i` does not wake it.
- R9: Cause bit 10 (misalign buffer full) wakes on `misalign_space_i`, and on no other space signal.
- R10: When several cause bits are set, only the lowest-numbered set bit governs wake-up. An event for a higher-numbered bit leaves the entry blocked.
- R11: A write at a clock edge shows on the outputs from that edge onward. `blocked_o` drops at the edge that ends the cycle in which the wake condition holds.
- R12: `ready_o[i]` = allocated & !scheduled & !blocked. A `grant_i` bit sets scheduled at the next edge, and a new write clears it.
- R13: A `free_i` bit deallocates the entry at the next edge, so both of its outputs go to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| enq_vld_i | input | 1 | Write an entry this cycle |
| enq_idx_i | input | IDX_W | Entry to write |
| enq_cause_i | input | 11 | Replay cause vector |
| enq_strict_i | input | 1 | Wait for all older store addresses (cause 0) |
| enq_sq_idx_i | input | SQ_W | Blocking store index |
| enq_miss_id_i | input | MISS_W | Cache-miss tracker ID |
| enq_hint_id_i | input | HINT_W | Translation-miss hint ID |
| enq_tlb_full_i | input | 1 | Translation unit could not track the miss |
| grant_i | input | N_ENTRIES | Entries picked for replay |
| free_i | input | N_ENTRIES | Entries released |
| st_addr_vld_i | input | 1 | Store address ready broadcast |
| st_addr_idx_i | input | SQ_W | Index of that store |
| st_data_vld_i | input | 1 | Store data ready broadcast |
| st_data_idx_i | input | SQ_W | Index of that store |
| tlb_hint_vld_i | input | 1 | Translation hint |
| tlb_hint_id_i | input | HINT_W | Hint ID |
| l2_hint_vld_i | input | 1 | Lower-cache refill hint |
| l2_hint_id_i | input | MISS_W | Miss tracker ID of hint |
| rar_space_i | input | 1 | Read-after-read queue has room |
| raw_space_i | input | 1 | Read-after-write queue has room |
| misalign_space_i | input | 1 | Misalign buffer has room |
| older_addr_done_i | input | N_ENTRIES | Per entry: all older stores have addresses |
| oldest_i | input | N_ENTRIES | Per entry: entry holds the oldest load |
| blocked_o | output | N_ENTRIES | Entry allocated and waiting for wake-up |
| ready_o | output | N_ENTRIES | Entry eligible for selection |

## Verification
Each cause is first written with the IDs it depends on. The bench then applies a near-miss event and checks that the entry stays blocked, and after that applies the correct event and checks that the entry wakes. The near-miss is either the right event with a wrong ID or index, or a plausible event of the wrong kind. This separates a correct per-cause rule from a merely permissive one. Multi-bit cause vectors are driven with an event for the higher-numbered bit to show that the lowest-numbered bit governs. The causes that need no event are checked for readiness straight after the write. A single lower-cache hint is sent to three entries, two holding the matching ID and one holding another ID, to show that the match is made per entry. Grant, rewrite and free sequences then exercise the scheduled and allocated state.

// File: rtl/rwt_pkg.sv
package rwt_pkg;
  localparam int N_CAUSE = 11;
  localparam int C_ORDER   = 0;
  localparam int C_XLATE   = 1;
  localparam int C_FWD     = 2;
  localparam int C_NOMSHR  = 3;
  localparam int C_MISS    = 4;
  localparam int C_WAY     = 5;
  localparam int C_BANK    = 6;
  localparam int C_RARFULL = 7;
  localparam int C_RAWFULL = 8;
  localparam int C_FWDVIOL = 9;
  localparam int C_MISALN  = 10;
  // causes replayable without any event
  localparam logic [N_CAUSE-1:0] IMM_MASK =
    N_CAUSE'((1 << C_NOMSHR) | (1 << C_WAY) | (1 << C_BANK) | (1 << C_FWDVIOL));
endpackage

// File: rtl/rwt_cause_pick.sv
module rwt_cause_pick #(
  parameter int W = 11
) (
  input  logic [W-1:0] cause_i,
  output logic [W-1:0] first_o
);
  for (genvar gi = 0; gi < W; gi++) begin : g_pick
    if (gi == 0) begin : g_lsb
      assign first_o[gi] = cause_i[gi];
    end else begin : g_rest
      assign first_o[gi] = cause_i[gi] & ~(|cause_i[gi-1:0]);
    end
  end
endmodule

// File: rtl/rwt_wake_eval.sv
module rwt_wake_eval
  import rwt_pkg::*;
#(
  parameter int SQ_W   = 4,
  parameter int MISS_W = 4,
  parameter int HINT_W = 3
) (
  input  logic [N_CAUSE-1:0] first_i,
  input  logic               strict_i,
  input  logic [SQ_W-1:0]    sq_idx_i,
  input  logic [MISS_W-1:0]  miss_id_i,
  input  logic [HINT_W-1:0]  hint_id_i,
  input  logic               st_addr_vld_i,
  input  logic [SQ_W-1:0]    st_addr_idx_i,
  input  logic               st_data_vld_i,
  input  logic [SQ_W-1:0]    st_data_idx_i,
  input  logic               tlb_hint_vld_i,
  input  logic [HINT_W-1:0]  tlb_hint_id_i,
  input  logic               l2_hint_vld_i,
  input  logic [MISS_W-1:0]  l2_hint_id_i,
  input  logic               rar_space_i,
  input  logic               raw_space_i,
  input  logic               misalign_space_i,
  input  logic               older_addr_done_i,
  input  logic               oldest_i,
  output logic               wake_o
);
  logic [N_CAUSE-1:0] cond;

  always_comb begin
    cond            = IMM_MASK;
    cond[C_ORDER]   = strict_i ? older_addr_done_i
                               : (st_addr_vld_i && st_addr_idx_i == sq_idx_i);
    cond[C_XLATE]   = tlb_hint_vld_i && tlb_hint_id_i == hint_id_i;
    cond[C_FWD]     = st_data_vld_i && st_data_idx_i == sq_idx_i;
    cond[C_MISS]    = l2_hint_vld_i && l2_hint_id_i == miss_id_i;
    cond[C_RARFULL] = rar_space_i || oldest_i;
    cond[C_RAWFULL] = raw_space_i || older_addr_done_i;
    cond[C_MISALN]  = misalign_space_i;
  end

  assign wake_o = |(first_i & cond);
endmodule

// File: rtl/rwt_entry.sv
module rwt_entry
  import rwt_pkg::*;
#(
  parameter int SQ_W   = 4,
  parameter int MISS_W = 4,
  parameter int HINT_W = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               enq_i,
  input  logic               enq_imm_i,
  input  logic [N_CAUSE-1:0] enq_cause_i,
  input  logic               enq_strict_i,
  input  logic [SQ_W-1:0]    enq_sq_idx_i,
  input  logic [MISS_W-1:0]  enq_miss_id_i,
  input  logic [HINT_W-1:0]  enq_hint_id_i,
  input  logic               grant_i,
  input  logic               free_i,
  input  logic               wake_i,
  output logic [N_CAUSE-1:0] cause_o,
  output logic               strict_o,
  output logic [SQ_W-1:0]    sq_idx_o,
  output logic [MISS_W-1:0]  miss_id_o,
  output logic [HINT_W-1:0]  hint_id_o,
  output logic               blocked_o,
  output logic               ready_o
);
  logic alloc_q, sched_q, blk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      alloc_q   <= 1'b0;
      sched_q   <= 1'b0;
      blk_q     <= 1'b0;
      cause_o   <= '0;
      strict_o  <= 1'b0;
      sq_idx_o  <= '0;
      miss_id_o <= '0;
      hint_id_o <= '0;
    end else if (enq_i) begin
      alloc_q   <= 1'b1;
      sched_q   <= 1'b0;
      blk_q     <= ~enq_imm_i;
      cause_o   <= enq_cause_i;
      strict_o  <= enq_strict_i;
      sq_idx_o  <= enq_sq_idx_i;
      miss_id_o <= enq_miss_id_i;
      hint_id_o <= enq_hint_id_i;
    end else begin
      if (free_i) alloc_q <= 1'b0;
      if (grant_i) sched_q <= 1'b1;
      if (blk_q && wake_i) blk_q <= 1'b0;
    end
  end

  assign blocked_o = alloc_q & blk_q;
  assign ready_o   = alloc_q & ~sched_q & ~blk_q;

  // R11
  enq_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enq_i |=> alloc_q && !sched_q);
  // R6
  imm_unblock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enq_i && enq_imm_i |=> !blk_q);
  // R12
  grant_sched_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_i && !enq_i && alloc_q |=> sched_q);
  // R13
  free_dealloc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    free_i && !enq_i |=> !alloc_q);
  // R10
  hold_blk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blk_q && !wake_i && !enq_i |=> blk_q);
endmodule

// File: rtl/replay_wakeup_tracker.sv
module replay_wakeup_tracker
  import rwt_pkg::*;
#(
  parameter int N_ENTRIES = 8,
  parameter int SQ_W      = 4,
  parameter int MISS_W    = 4,
  parameter int HINT_W    = 3,
  localparam int IDX_W    = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 enq_vld_i,
  input  logic [IDX_W-1:0]     enq_idx_i,
  input  logic [N_CAUSE-1:0]   enq_cause_i,
  input  logic                 enq_strict_i,
  input  logic [SQ_W-1:0]      enq_sq_idx_i,
  input  logic [MISS_W-1:0]    enq_miss_id_i,
  input  logic [HINT_W-1:0]    enq_hint_id_i,
  input  logic                 enq_tlb_full_i,
  input  logic [N_ENTRIES-1:0] grant_i,
  input  logic [N_ENTRIES-1:0] free_i,
  input  logic                 st_addr_vld_i,
  input  logic [SQ_W-1:0]      st_addr_idx_i,
  input  logic                 st_data_vld_i,
  input  logic [SQ_W-1:0]      st_data_idx_i,
  input  logic                 tlb_hint_vld_i,
  input  logic [HINT_W-1:0]    tlb_hint_id_i,
  input  logic                 l2_hint_vld_i,
  input  logic [MISS_W-1:0]    l2_hint_id_i,
  input  logic                 rar_space_i,
  input  logic                 raw_space_i,
  input  logic                 misalign_space_i,
  input  logic [N_ENTRIES-1:0] older_addr_done_i,
  input  logic [N_ENTRIES-1:0] oldest_i,
  output logic [N_ENTRIES-1:0] blocked_o,
  output logic [N_ENTRIES-1:0] ready_o
);
  logic [N_CAUSE-1:0] enq_first;
  logic               enq_imm;

  rwt_cause_pick #(.W(N_CAUSE)) u_enq_pick (.cause_i(enq_cause_i), .first_o(enq_first));

  // no cause, an event-free cause, or a translation miss the unit could not track
  assign enq_imm = ~(|enq_cause_i) | (|(enq_first & IMM_MASK)) |
                   (enq_first[C_XLATE] & enq_tlb_full_i);

  for (genvar gi = 0; gi < N_ENTRIES; gi++) begin : g_ent
    logic [N_CAUSE-1:0] cause, first;
    logic               strict, wake, enq_hit;
    logic [SQ_W-1:0]    sq_idx;
    logic [MISS_W-1:0]  miss_id;
    logic [HINT_W-1:0]  hint_id;

    assign enq_hit = enq_vld_i && (enq_idx_i == IDX_W'(gi));

    rwt_cause_pick #(.W(N_CAUSE)) u_pick (.cause_i(cause), .first_o(first));

    rwt_wake_eval #(.SQ_W(SQ_W), .MISS_W(MISS_W), .HINT_W(HINT_W)) u_wake (
      .first_i(first), .strict_i(strict), .sq_idx_i(sq_idx),
      .miss_id_i(miss_id), .hint_id_i(hint_id),
      .st_addr_vld_i(st_addr_vld_i), .st_addr_idx_i(st_addr_idx_i),
      .st_data_vld_i(st_data_vld_i), .st_data_idx_i(st_data_idx_i),
      .tlb_hint_vld_i(tlb_hint_vld_i), .tlb_hint_id_i(tlb_hint_id_i),
      .l2_hint_vld_i(l2_hint_vld_i), .l2_hint_id_i(l2_hint_id_i),
      .rar_space_i(rar_space_i), .raw_space_i(raw_space_i),
      .misalign_space_i(misalign_space_i),
      .older_addr_done_i(older_addr_done_i[gi]), .oldest_i(oldest_i[gi]),
      .wake_o(wake));

    rwt_entry #(.SQ_W(SQ_W), .MISS_W(MISS_W), .HINT_W(HINT_W)) u_entry (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .enq_i(enq_hit), .enq_imm_i(enq_imm), .enq_cause_i(enq_cause_i),
      .enq_strict_i(enq_strict_i), .enq_sq_idx_i(enq_sq_idx_i),
      .enq_miss_id_i(enq_miss_id_i), .enq_hint_id_i(enq_hint_id_i),
      .grant_i(grant_i[gi]), .free_i(free_i[gi]), .wake_i(wake),
      .cause_o(cause), .strict_o(strict), .sq_idx_o(sq_idx),
      .miss_id_o(miss_id), .hint_id_o(hint_id),
      .blocked_o(blocked_o[gi]), .ready_o(ready_o[gi]));
  end

  // R12
  ready_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o & blocked_o) == '0);
  // R5
  l2_wake_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !l2_hint_vld_i && !enq_vld_i && blocked_o[0] && g_ent[0].first[C_MISS]
    |=> blocked_o[0]);
endmodule

// File: tb/tb_replay_wakeup_tracker.sv
module tb_replay_wakeup_tracker;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 8;
  localparam logic [3:0] SQ  = 4'd5;
  localparam logic [3:0] MID = 4'd9;
  localparam logic [2:0] HID = 3'd3;

  typedef struct packed {
    logic [10:0] cause;
    logic        strict;
    logic        tlbfull;
    logic        imm;
    logic [3:0]  bad_ev;
    logic        bad_mis;
    logic [3:0]  good_ev;
    logic [3:0]  req;
  } vec_t;

  // event codes: 1 st_addr, 2 older_done, 3 st_data, 4 tlb hint, 5 l2 hint,
  // 6 rar space, 7 oldest, 8 raw space, 9 misalign space
  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{11'h001, 1'b0, 1'b0, 1'b0, 4'd1, 1'b1, 4'd1, 4'd2},  // R2 single-store
    '{11'h001, 1'b1, 1'b0, 1'b0, 4'd1, 1'b0, 4'd2, 4'd2},  // R2 strict
    '{11'h002, 1'b0, 1'b0, 1'b0, 4'd4, 1'b1, 4'd4, 4'd3},  // R3 hint
    '{11'h002, 1'b0, 1'b1, 1'b1, 4'd0, 1'b0, 4'd0, 4'd3},  // R3 unit full
    '{11'h004, 1'b0, 1'b0, 1'b0, 4'd1, 1'b0, 4'd3, 4'd4},  // R4
    '{11'h010, 1'b0, 1'b0, 1'b0, 4'd5, 1'b1, 4'd5, 4'd5},  // R5
    '{11'h008, 1'b0, 1'b0, 1'b1, 4'd0, 1'b0, 4'd0, 4'd6},  // R6
    '{11'h020, 1'b0, 1'b0, 1'b1, 4'd0, 1'b0, 4'd0, 4'd6},  // R6
    '{11'h040, 1'b0, 1'b0, 1'b1, 4'd0, 1'b0, 4'd0, 4'd6},  // R6
    '{11'h200, 1'b0, 1'b0, 1'b1, 4'd0, 1'b0, 4'd0, 4'd6},  // R6
    '{11'h000, 1'b0, 1'b0, 1'b1, 4'd0, 1'b0, 4'd0, 4'd6},  // R6 empty
    '{11'h080, 1'b0, 1'b0, 1'b0, 4'd8, 1'b0, 4'd6, 4'd7},  // R7 space
    '{11'h080, 1'b0, 1'b0, 1'b0, 4'd2, 1'b0, 4'd7, 4'd7},  // R7 oldest
    '{11'h100, 1'b0, 1'b0, 1'b0, 4'd6, 1'b0, 4'd8, 4'd8},  // R8 space
    '{11'h100, 1'b0, 1'b0, 1'b0, 4'd7, 1'b0, 4'd2, 4'd8},  // R8 older done
    '{11'h400, 1'b0, 1'b0, 1'b0, 4'd6, 1'b0, 4'd9, 4'd9},  // R9
    '{11'h012, 1'b0, 1'b0, 1'b0, 4'd5, 1'b0, 4'd4, 4'd10}, // R10 bits 1,4
    '{11'h090, 1'b0, 1'b0, 1'b0, 4'd6, 1'b0, 4'd5, 4'd10}  // R10 bits 4,7
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic enq_vld = 1'b0, enq_strict = 1'b0, enq_tlb_full = 1'b0;
  logic [2:0] enq_idx = '0;
  logic [10:0] enq_cause = '0;
  logic [3:0] enq_sq = '0, enq_mid = '0;
  logic [2:0] enq_hid = '0;
  logic [N-1:0] grant = '0, free = '0, older_done = '0, oldest = '0;
  logic st_addr_vld = 1'b0, st_data_vld = 1'b0, tlb_vld = 1'b0, l2_vld = 1'b0;
  logic [3:0] st_addr_idx = '0, st_data_idx = '0, l2_id = '0;
  logic [2:0] tlb_id = '0;
  logic rar_sp = 1'b0, raw_sp = 1'b0, mis_sp = 1'b0;
  logic [N-1:0] blocked, ready;
  int checks = 0, errors = 0, cycles = 0;
  bit done = 1'b0;

  replay_wakeup_tracker dut (
    .clk_i(clk), .rst_ni(rst_n),
    .enq_vld_i(enq_vld), .enq_idx_i(enq_idx), .enq_cause_i(enq_cause),
    .enq_strict_i(enq_strict), .enq_sq_idx_i(enq_sq), .enq_miss_id_i(enq_mid),
    .enq_hint_id_i(enq_hid), .enq_tlb_full_i(enq_tlb_full),
    .grant_i(grant), .free_i(free),
    .st_addr_vld_i(st_addr_vld), .st_addr_idx_i(st_addr_idx),
    .st_data_vld_i(st_data_vld), .st_data_idx_i(st_data_idx),
    .tlb_hint_vld_i(tlb_vld), .tlb_hint_id_i(tlb_id),
    .l2_hint_vld_i(l2_vld), .l2_hint_id_i(l2_id),
    .rar_space_i(rar_sp), .raw_space_i(raw_sp), .misalign_space_i(mis_sp),
    .older_addr_done_i(older_done), .oldest_i(oldest),
    .blocked_o(blocked), .ready_o(ready));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      errors++;
      $display("FAIL watchdog: run hung, actual cycles %0d expected < 20000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic clear_ev();
    st_addr_vld = 0; st_data_vld = 0; tlb_vld = 0; l2_vld = 0;
    rar_sp = 0; raw_sp = 0; mis_sp = 0; older_done = '0; oldest = '0;
    grant = '0; free = '0; enq_vld = 0;
  endtask

  task automatic drive_ev(input logic [3:0] ev, input logic mis, input int e);
    case (ev)
      4'd1: begin st_addr_vld = 1; st_addr_idx = mis ? (SQ ^ 4'd1) : SQ; end
      4'd2: older_done = N'(1) << (mis ? (e ^ 1) : e);
      4'd3: begin st_data_vld = 1; st_data_idx = mis ? (SQ ^ 4'd1) : SQ; end
      4'd4: begin tlb_vld = 1; tlb_id = mis ? (HID ^ 3'd1) : HID; end
      4'd5: begin l2_vld = 1; l2_id = mis ? (MID ^ 4'd1) : MID; end
      4'd6: rar_sp = 1;
      4'd7: oldest = N'(1) << (mis ? (e ^ 1) : e);
      4'd8: raw_sp = 1;
      4'd9: mis_sp = 1;
      default: ;
    endcase
  endtask

  task automatic enq(input int e, input logic [10:0] c, input logic s,
                     input logic tf, input logic [3:0] mid);
    enq_vld = 1; enq_idx = 3'(e); enq_cause = c; enq_strict = s;
    enq_tlb_full = tf; enq_sq = SQ; enq_mid = mid; enq_hid = HID;
    step();
    enq_vld = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 2 + 1);
    chk("R1 blocked after reset", blocked, '0);
    chk("R1 ready after reset", ready, '0);
    @(negedge clk);
    rst_n = 1'b1;
    step();

    for (int k = 0; k < NV; k++) begin
      automatic vec_t v = VECS[k];
      automatic int e = k % N;
      automatic string tag = $sformatf("R%0d vec%0d", v.req, k);
      enq(e, v.cause, v.strict, v.tlbfull, MID);
      // R11: state visible one edge after the write
      chk({tag, " R11 blocked after write"}, N'(blocked[e]), N'(!v.imm));
      chk({tag, " R11 ready after write"}, N'(ready[e]), N'(v.imm));
      if (!v.imm) begin
        drive_ev(v.bad_ev, v.bad_mis, e);
        step();
        clear_ev();
        chk({tag, " near-miss event must not wake"}, N'(blocked[e]), N'(1));
        drive_ev(v.good_ev, 1'b0, e);
        step();
        clear_ev();
        chk({tag, " blocked after matching event"}, N'(blocked[e]), N'(0));
        chk({tag, " ready after matching event"}, N'(ready[e]), N'(1));
      end
    end

    // R12: grant then rewrite
    grant = N'(1);
    step();
    clear_ev();
    chk("R12 ready after grant", N'(ready[0]), N'(0));
    enq(0, 11'h020, 1'b0, 1'b0, MID);
    chk("R12 ready after rewrite", N'(ready[0]), N'(1));

    // R13: free
    free = N'(1);
    step();
    clear_ev();
    chk("R13 ready after free", N'(ready[0]), N'(0));
    chk("R13 blocked after free", N'(blocked[0]), N'(0));

    // R5: one hint, two matching entries, one other ID
    enq(1, 11'h010, 1'b0, 1'b0, MID);
    enq(2, 11'h010, 1'b0, 1'b0, MID);
    enq(3, 11'h010, 1'b0, 1'b0, MID ^ 4'd2);
    chk("R5 three blocked before hint", N'(blocked[3:1]), N'(3'b111));
    l2_vld = 1; l2_id = MID;
    step();
    clear_ev();
    chk("R5 broadcast hint wakes matching IDs only", N'(blocked[3:1]), N'(3'b100));
    chk("R5 ready after broadcast", N'(ready[3:1]), N'(3'b011));

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule